// File: doc/BRIEF.md
# I2C Byte Event and Clock-Stretch Controller

This block sits inside an I2C peripheral and decides, for each byte on the bus, on which falling SCL edge a byte interrupt fires and whether SCL is then held low as a wait. It counts falling edges from 1 to 9 within a byte, using a one-cycle falling-edge strobe supplied by the SCL front end. It combines that count with the transfer phase (address, data receive, data transmit), the master or slave role, and the outcome of the slave address comparison. Start and stop detection, the shift register and the pad drivers are outside the block. They reach it as strobes and levels.

For data bytes a timing-select input picks the 8th or the 9th falling edge as the event point. Address bytes follow fixed rules that depend on the role, on an own-address match, on an extension code and on whether the byte follows a repeated start. Software ends a wait through one of four release strobes. Two of them only take effect in the master role. The acknowledge level is latched when the wait is released, and it is forced to acknowledge on a slave address match.

Top module: `i2c_byte_event_ctrl`

## Requirements
- R1: Falling edges are numbered 1 to 9 within a byte. `irq` is high for exactly one clock cycle: the cycle after the clock in which `scl_fall` carries the event edge.
- R2: In a data phase (`phase` 2'b01 receive or 2'b10 transmit), in either role, the interrupt and the wait occur on edge 8 when `late_sel`=0 and on edge 9 when `late_sel`=1.
- R3: In the master role the address phase (`phase` 2'b00) gives the interrupt and the wait on edge 9, whatever `late_sel` is.
- R4: In the slave role, an address phase with `addr_match`=1 gives the interrupt and the wait on edge 9, whatever `late_sel` is.
- R5: On a slave address match, `ack_low` (1 = drive SDA low) is set from edge 8 onward, even when `ack_en`=0.
- R6: In a slave address phase with `ext_code`=1 and no match, the interrupt and the wait occur on edge 8.
- R7: In a slave address phase that follows a repeated start (a `bus_start` with no `bus_stop` since the previous `bus_start`), with no match and no extension code, the interrupt fires on edge 9 and no wait is inserted.
- R8: In a slave address phase with no match, no extension code and no repeated start, neither an interrupt nor a wait occurs.
- R9: An active wait is released by `rel_wrel` or `rel_data_wr`. `scl_hold` drops in the same cycle as the strobe and stays low afterwards.
- R10: `rel_start` and `rel_stop` release a wait only in the master role. In the slave role they have no effect and `scl_hold` stays high.
- R11: When a wait is released, `ack_low` takes the value of `ack_en`. Changes of `ack_en` at any other time leave `ack_low` unchanged.
- R12: A `bus_start` or `bus_stop` strobe clears the edge count, so the next falling edge is edge 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_fall | input | 1 | One-cycle strobe per falling SCL edge |
| bus_start | input | 1 | Start or repeated-start condition detected |
| bus_stop | input | 1 | Stop condition detected |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| phase | input | 2 | 00 address, 01 data receive, 10 data transmit |
| addr_match | input | 1 | Received address equals own address |
| ext_code | input | 1 | Received address is an extension code |
| late_sel | input | 1 | Data event point: 0 = edge 8, 1 = edge 9 |
| ack_en | input | 1 | Software acknowledge enable |
| rel_wrel | input | 1 | Wait-release bit written as 1 |
| rel_data_wr | input | 1 | Data register written |
| rel_start | input | 1 | Start-condition request (master only) |
| rel_stop | input | 1 | Stop-condition request (master only) |
| irq | output | 1 | Byte interrupt pulse |
| scl_hold | output | 1 | Hold SCL low (wait active) |
| ack_low | output | 1 | 1 = drive acknowledge (SDA low) |

## Verification
The bench sweeps every combination of role, phase, timing select and address outcome. It checks the interrupt and the hold on each of the nine edges, so a design that counted edges off by one, or applied `late_sel` to address bytes, would raise the event on the wrong edge. The repeated-start no-match case is checked for an interrupt with no hold; a design that shared the match path would stretch the clock there. Start and stop requests are sent during a slave wait, where a design that did not check the role would release SCL too early. `ack_en` is toggled outside a release to catch an acknowledge that is not latched, and a byte is cut short by start and stop strobes to catch a counter that does not clear.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;
   typedef enum logic [1:0] {
      PH_ADDR = 2'b00,
      PH_RX   = 2'b01,
      PH_TX   = 2'b10,
      PH_RSVD = 2'b11
   } phase_e;

   typedef struct packed {
      logic fire;
      logic hold;
      logic force_ack;
   } evt_t;
endpackage

// File: rtl/i2c_evt_bitcnt.sv
module i2c_evt_bitcnt #(
   parameter int BYTE_BITS = 8,
   localparam int CNT_W = $clog2(BYTE_BITS + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_fall,
   input  logic             clr,
   output logic [CNT_W-1:0] edge_num
);
   localparam int SLOT = BYTE_BITS + 1;

   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      if (cnt_q == CNT_W'(SLOT)) edge_num = CNT_W'(1);
      else                       edge_num = cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (clr)      cnt_q <= '0;
      else if (scl_fall) cnt_q <= edge_num;
   end
endmodule

// File: rtl/i2c_evt_decode.sv
module i2c_evt_decode
   import i2c_evt_pkg::*;
#(
   parameter int BYTE_BITS = 8,
   localparam int CNT_W = $clog2(BYTE_BITS + 2)
) (
   input  logic             scl_fall,
   input  logic [CNT_W-1:0] edge_num,
   input  logic             is_master,
   input  logic [1:0]       phase,
   input  logic             addr_match,
   input  logic             ext_code,
   input  logic             restart,
   input  logic             late_sel,
   output evt_t             evt
);
   localparam int EARLY = BYTE_BITS;
   localparam int LATE  = BYTE_BITS + 1;

   logic at_early, at_late, at_data;

   assign at_early = (edge_num == CNT_W'(EARLY));
   assign at_late  = (edge_num == CNT_W'(LATE));
   assign at_data  = late_sel ? at_late : at_early;

   always_comb begin
      evt = '0;
      if (scl_fall) begin
         if (phase_e'(phase) == PH_ADDR) begin
            if (is_master) begin
               evt.fire = at_late;
               evt.hold = at_late;
            end else if (addr_match) begin
               evt.force_ack = at_early;
               evt.fire      = at_late;
               evt.hold      = at_late;
            end else if (ext_code) begin
               evt.fire = at_early;
               evt.hold = at_early;
            end else if (restart) begin
               evt.fire = at_late;
            end
         end else begin
            evt.fire = at_data;
            evt.hold = at_data;
         end
      end
   end
endmodule

// File: rtl/i2c_evt_wait.sv
module i2c_evt_wait
   import i2c_evt_pkg::*;
#(
   parameter bit HOLD_FAST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  evt_t evt,
   input  logic is_master,
   input  logic ack_en,
   input  logic rel_wrel,
   input  logic rel_data_wr,
   input  logic rel_start,
   input  logic rel_stop,
   output logic irq,
   output logic scl_hold,
   output logic ack_low,
   output logic wait_active
);
   logic rel_any, rel_ok;
   logic irq_q, wait_q, ack_q;

   assign rel_any = rel_wrel | rel_data_wr | (is_master & (rel_start | rel_stop));
   assign rel_ok  = wait_q & rel_any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q  <= 1'b0;
         wait_q <= 1'b0;
         ack_q  <= 1'b0;
      end else begin
         irq_q <= evt.fire;
         if (evt.hold)    wait_q <= 1'b1;
         else if (rel_ok) wait_q <= 1'b0;
         if (evt.force_ack) ack_q <= 1'b1;
         else if (rel_ok)   ack_q <= ack_en;
      end
   end

   generate
      if (HOLD_FAST) begin : g_fast_release
         assign scl_hold = wait_q & ~rel_any;
      end else begin : g_reg_release
         assign scl_hold = wait_q;
      end
   endgenerate

   assign irq         = irq_q;
   assign ack_low     = ack_q;
   assign wait_active = wait_q;
endmodule

// File: rtl/i2c_byte_event_ctrl.sv
module i2c_byte_event_ctrl
   import i2c_evt_pkg::*;
#(
   parameter int BYTE_BITS = 8,
   parameter bit HOLD_FAST = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_fall,
   input  logic       bus_start,
   input  logic       bus_stop,
   input  logic       is_master,
   input  logic [1:0] phase,
   input  logic       addr_match,
   input  logic       ext_code,
   input  logic       late_sel,
   input  logic       ack_en,
   input  logic       rel_wrel,
   input  logic       rel_data_wr,
   input  logic       rel_start,
   input  logic       rel_stop,
   output logic       irq,
   output logic       scl_hold,
   output logic       ack_low
);
   localparam int CNT_W = $clog2(BYTE_BITS + 2);

   generate
      if (BYTE_BITS < 2 || BYTE_BITS > 16) begin : g_bad_byte_bits
         $error("BYTE_BITS out of supported range 2..16");
      end
   endgenerate

   logic             busy_q, restart_q;
   logic [CNT_W-1:0] edge_num;
   logic             wait_active;
   evt_t             evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         restart_q <= 1'b0;
      end else if (bus_stop) begin
         busy_q    <= 1'b0;
         restart_q <= 1'b0;
      end else if (bus_start) begin
         restart_q <= busy_q;
         busy_q    <= 1'b1;
      end
   end

   i2c_evt_bitcnt #(.BYTE_BITS(BYTE_BITS)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_fall (scl_fall),
      .clr      (bus_start | bus_stop),
      .edge_num (edge_num)
   );

   i2c_evt_decode #(.BYTE_BITS(BYTE_BITS)) u_dec (
      .scl_fall   (scl_fall),
      .edge_num   (edge_num),
      .is_master  (is_master),
      .phase      (phase),
      .addr_match (addr_match),
      .ext_code   (ext_code),
      .restart    (restart_q),
      .late_sel   (late_sel),
      .evt        (evt)
   );

   i2c_evt_wait #(.HOLD_FAST(HOLD_FAST)) u_wait (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt         (evt),
      .is_master   (is_master),
      .ack_en      (ack_en),
      .rel_wrel    (rel_wrel),
      .rel_data_wr (rel_data_wr),
      .rel_start   (rel_start),
      .rel_stop    (rel_stop),
      .irq         (irq),
      .scl_hold    (scl_hold),
      .ack_low     (ack_low),
      .wait_active (wait_active)
   );
endmodule

// File: rtl/i2c_byte_event_chk.sv
module i2c_byte_event_chk #(
   parameter bit HOLD_FAST = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       scl_fall,
   input logic       is_master,
   input logic [1:0] phase,
   input logic       addr_match,
   input logic       ext_code,
   input logic       rel_wrel,
   input logic       rel_data_wr,
   input logic       irq,
   input logic       scl_hold,
   input logic       ack_low,
   input logic       wait_active
);
   AST_IRQ_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(scl_fall)); // R1

   AST_HOLD_STARTS_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wait_active) |-> irq); // R1

   AST_MATCH_ACK_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !is_master && phase == 2'b00 && addr_match) |-> ack_low); // R5

   AST_NO_WAIT_UNMATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !is_master && phase == 2'b00 && !addr_match && !ext_code) |-> !wait_active); // R7

   AST_SLAVE_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_active && !is_master && !rel_wrel && !rel_data_wr) |=> wait_active); // R10

   generate
      if (HOLD_FAST) begin : g_fast_chk
         AST_RELEASE_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
            (wait_active && (rel_wrel || rel_data_wr)) |-> !scl_hold); // R9
      end
   endgenerate
endmodule

bind i2c_byte_event_ctrl i2c_byte_event_chk #(.HOLD_FAST(HOLD_FAST)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .scl_fall    (scl_fall),
   .is_master   (is_master),
   .phase       (phase),
   .addr_match  (addr_match),
   .ext_code    (ext_code),
   .rel_wrel    (rel_wrel),
   .rel_data_wr (rel_data_wr),
   .irq         (irq),
   .scl_hold    (scl_hold),
   .ack_low     (ack_low),
   .wait_active (wait_active)
);

// File: tb/tb_i2c_byte_event_ctrl.sv
`timescale 1ns/1ps
module tb_i2c_byte_event_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_fall = 0, bus_start = 0, bus_stop = 0, is_master = 0;
   logic [1:0] phase = 2'b00;
   logic addr_match = 0, ext_code = 0, late_sel = 0, ack_en = 0;
   logic rel_wrel = 0, rel_data_wr = 0, rel_start = 0, rel_stop = 0;
   logic irq, scl_hold, ack_low;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   i2c_byte_event_ctrl dut (
      .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .bus_start(bus_start),
      .bus_stop(bus_stop), .is_master(is_master), .phase(phase),
      .addr_match(addr_match), .ext_code(ext_code), .late_sel(late_sel),
      .ack_en(ack_en), .rel_wrel(rel_wrel), .rel_data_wr(rel_data_wr),
      .rel_start(rel_start), .rel_stop(rel_stop), .irq(irq),
      .scl_hold(scl_hold), .ack_low(ack_low)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic pulse_start();
      bus_start = 1; @(negedge clk); bus_start = 0; @(negedge clk);
   endtask

   task automatic pulse_stop();
      bus_stop = 1; @(negedge clk); bus_stop = 0; @(negedge clk);
   endtask

   // one falling edge; returns one cycle after the strobe (irq visible)
   task automatic fall();
      scl_fall = 1; @(negedge clk); scl_fall = 0; #1;
   endtask

   task automatic release_by(input int src, input string req);
      case (src)
         0: rel_wrel = 1;
         1: rel_data_wr = 1;
         2: rel_start = 1;
         default: rel_stop = 1;
      endcase
      #1;
      chk(scl_hold == 0, req, scl_hold, 0);
      @(negedge clk);
      rel_wrel = 0; rel_data_wr = 0; rel_start = 0; rel_stop = 0;
      #1;
      chk(scl_hold == 0, req, scl_hold, 0);
   endtask

   // one byte with expected event point computed from the requirements
   task automatic run_byte(input bit m, input logic [1:0] ph, input bit late,
                           input bit mt, input bit ex, input bit rs, input int src);
      int pos; bit wt; string req;
      pos = 0; wt = 0;
      if (ph != 2'b00) begin pos = late ? 9 : 8; wt = 1; req = "R2"; end
      else if (m)      begin pos = 9; wt = 1; req = "R3"; end
      else if (mt)     begin pos = 9; wt = 1; req = "R4"; end
      else if (ex)     begin pos = 8; wt = 1; req = "R6"; end
      else if (rs)     begin pos = 9; wt = 0; req = "R7"; end
      else             req = "R8";
      is_master = m; phase = ph; late_sel = late; addr_match = mt; ext_code = ex;
      ack_en = 0;
      pulse_start();
      if (rs) pulse_start();
      for (int k = 1; k <= 9; k++) begin
         fall();
         chk(irq == (k == pos), req, irq, (k == pos));
         chk(scl_hold == (k == pos && wt), req, scl_hold, (k == pos && wt));
         if (!m && ph == 2'b00 && mt && k == 8)
            chk(ack_low == 1, "R5", ack_low, 1);
         @(negedge clk); #1;
         chk(irq == 0, "R1", irq, 0);
         if (k == pos && wt) begin
            chk(scl_hold == 1, req, scl_hold, 1);
            release_by(src, "R9");
         end
         @(negedge clk);
      end
      pulse_stop();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int it;
      it = 0;
      repeat (3) @(negedge clk);
      #1;
      chk(irq == 0 && scl_hold == 0 && ack_low == 0, "R1", {irq, scl_hold, ack_low}, 0);
      rst_n = 1;
      @(negedge clk);

      // sweep over role, phase and timing select (R2, R3)
      for (int m = 0; m < 2; m++)
         for (int ph = 0; ph < 3; ph++)
            for (int lt = 0; lt < 2; lt++)
               if (m == 1 || ph != 0) begin
                  run_byte(m[0], ph[1:0], lt[0], 0, 0, 0, m ? (it % 4) : (it % 2));
                  it++;
               end

      // slave address outcomes (R4, R6, R7, R8)
      for (int lt = 0; lt < 2; lt++)
         for (int mt = 0; mt < 2; mt++)
            for (int ex = 0; ex < 2; ex++)
               for (int rs = 0; rs < 2; rs++) begin
                  run_byte(0, 2'b00, lt[0], mt[0], ex[0], rs[0], it % 2);
                  it++;
               end

      // R10: start/stop requests ignored by a slave in a wait
      is_master = 0; phase = 2'b01; late_sel = 0; addr_match = 0; ext_code = 0;
      pulse_start();
      for (int k = 1; k <= 8; k++) begin fall(); @(negedge clk); end
      #1;
      chk(scl_hold == 1, "R10", scl_hold, 1);
      rel_start = 1; #1;
      chk(scl_hold == 1, "R10", scl_hold, 1);
      @(negedge clk); rel_start = 0; rel_stop = 1; #1;
      chk(scl_hold == 1, "R10", scl_hold, 1);
      @(negedge clk); rel_stop = 0; @(negedge clk); #1;
      chk(scl_hold == 1, "R10", scl_hold, 1);

      // R11: ack_en ignored while waiting, latched on release
      chk(ack_low == 0, "R11", ack_low, 0);
      ack_en = 1; @(negedge clk); @(negedge clk); #1;
      chk(ack_low == 0, "R11", ack_low, 0);
      release_by(1, "R9");
      chk(ack_low == 1, "R11", ack_low, 1);
      ack_en = 0; @(negedge clk); @(negedge clk); #1;
      chk(ack_low == 1, "R11", ack_low, 1);
      fall(); @(negedge clk);
      pulse_stop();

      // R12: counter cleared by start and by stop mid-byte
      is_master = 1; phase = 2'b10; late_sel = 0;
      pulse_start();
      for (int k = 1; k <= 5; k++) begin fall(); @(negedge clk); end
      pulse_start();
      for (int k = 1; k <= 8; k++) begin
         fall();
         chk(irq == (k == 8), "R12", irq, (k == 8));
         @(negedge clk);
      end
      ack_en = 0;
      release_by(0, "R9");
      chk(ack_low == 0, "R11", ack_low, 0);
      for (int k = 1; k <= 3; k++) begin fall(); @(negedge clk); end
      pulse_stop();
      for (int k = 1; k <= 8; k++) begin
         fall();
         chk(irq == (k == 8), "R12", irq, (k == 8));
         @(negedge clk);
      end
      release_by(3, "R10");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule